// File: doc/BRIEF.md
# Interleaved Three-Channel Timer Register Bank

This block is the software-visible register front end for three identical timer channels. It sits on a simple request bus carrying valid, write, byte address and write data. It holds each channel's configuration: clock setup, run control, reload limit, three compare values, interrupt enable mask and event setup. It returns each channel's live count and event count, which arrive on input pins from the counter channels. It keeps a sticky interrupt flag set per channel. Reading that set returns the flags and clears them in the same access. Each channel has its own registered interrupt line.

The address space is interleaved by word. Take the word index as the byte address shifted right by two. That word index divided by three gives the register kind, and the remainder gives the channel. The three copies of one register kind therefore sit in three neighbouring words, and each new kind begins twelve bytes after the previous one. The request side never stalls: `req_ready` is held high, and every request is taken on the edge where `req_valid` is high. A read answers with a one-cycle `rsp_valid` pulse on the following cycle. The response has no back-pressure, so the requester must take it in that cycle.

Top module: `tmr_bank`

## Requirements
- R1: An access is mapped only when `req_addr[1:0]` is zero and the register kind is below 11. With w = `req_addr >> 2`, the kind is w / 3 and the channel is w % 3.
- R2: Register kinds by number: 0 clock setup, 1 run control, 2 live count, 3 reload limit, 4/5/6 compare 0/1/2, 7 interrupt flags, 8 interrupt enable, 9 event setup, 10 event count. For example, byte 0x24 is the reload limit of channel 0 and byte 0x78 is the event count of channel 0.
- R3: Clock setup, run control and interrupt enable store only write data bits 5:0. Event setup stores bits 2:0. Reload limit and the compare values store bits 15:0. Reads return the stored value zero-extended.
- R4: After reset, run control reads 0x21 on every channel (bit 0 set, so the channel is held stopped). Every other stored register reads 0, and all `irq_o` bits are 0.
- R5: `req_ready` is always 1. A read taken on an edge gives `rsp_valid` high for exactly the next cycle, with its data. Writes give no response.
- R6: Live count and event count are read-only. They return the channel's 16-bit input, zero-extended to 32 bits and sampled at the request edge. Writes to them change nothing.
- R7: Each bit of a channel's `ch_flag_set_i` field raises the matching sticky flag bit. The flag stays set until that channel's flag register is read.
- R8: A read of a channel's flags returns the flags held before the edge and clears them. A flag raised on that same edge survives the clear.
- R9: Writes to the interrupt flag registers change no flag.
- R10: An unmapped read returns 0. An unmapped write changes no register.
- R11: `irq_o[c]` at one edge equals the OR of channel c's flags AND its enable mask as held before that edge, so it follows a change after one cycle.
- R12: The configuration outputs to the channels always carry the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| ch_count_i | input | 48 | Live 16-bit count per channel, channel c at bits 16c+15:16c |
| ch_evcount_i | input | 48 | Event count per channel, same packing |
| ch_flag_set_i | input | 18 | Flag set pulses, 6 per channel, channel c at bits 6c+5:6c |
| ch_clk_cfg_o | output | 18 | Clock setup per channel |
| ch_run_cfg_o | output | 18 | Run control per channel |
| ch_limit_o | output | 48 | Reload limit per channel |
| ch_cmp_o | output | 144 | Compare values, compare m of channel c at bits 16(3c+m)+15 down |
| ch_ev_cfg_o | output | 9 | Event setup per channel, 3 bits each |
| irq_o | output | 3 | Interrupt line per channel |

## Verification
The hardest situation to reach from the ports is a flag set pulse that lands on the very edge where the same channel's flag register is read and cleared. The stimulus drives the pulse and the read request at the same falling edge. It then checks that the read returns only the older flags, and that a second read returns exactly the new ones. Seeded random traffic mixes aligned, unaligned and out-of-range addresses with flag pulses and changing live counts. After every operation, each interrupt line is compared against the flags and enables the bench has modelled.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int CNT_W     = 16;
  localparam int CTRL_W    = 6;
  localparam int EVCFG_W   = 3;
  localparam int FLAG_W    = 6;
  localparam int NUM_CMP   = 3;
  localparam int GRP_W     = 4;
  localparam int NUM_GRP   = 11;
  localparam logic [CTRL_W-1:0] RUN_CFG_RST = 6'h21;

  typedef enum logic [GRP_W-1:0] {
    G_CLKCFG = 4'd0,
    G_RUNCFG = 4'd1,
    G_COUNT  = 4'd2,
    G_LIMIT  = 4'd3,
    G_CMP0   = 4'd4,
    G_CMP1   = 4'd5,
    G_CMP2   = 4'd6,
    G_FLAGS  = 4'd7,
    G_FLAGEN = 4'd8,
    G_EVCFG  = 4'd9,
    G_EVCNT  = 4'd10
  } grp_e;

  localparam int CMP_BASE = int'(G_CMP0);
endpackage

// File: rtl/tmr_bank_decode.sv
module tmr_bank_decode
  import tmr_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output grp_e              grp,
  output logic [CH_W-1:0]   ch
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] kind;

  assign word = addr[ADDR_W-1:2];

  // Interleaved layout (R1): kind is word / NUM_CH, channel the remainder
  always_comb begin
    kind = WORD_W'(word / NUM_CH);
    ch   = CH_W'(word % NUM_CH);
    hit  = (addr[1:0] == 2'b00) && (int'(kind) < NUM_GRP);
    grp  = grp_e'(kind[GRP_W-1:0]);
  end
endmodule

// File: rtl/tmr_bank_chan_regs.sv
module tmr_bank_chan_regs
  import tmr_bank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  grp_e                     grp,
  input  logic [CNT_W-1:0]         wdata,
  input  logic                     flag_clr,
  input  logic [FLAG_W-1:0]        flag_set,
  output logic [CTRL_W-1:0]        clk_cfg,
  output logic [CTRL_W-1:0]        run_cfg,
  output logic [CNT_W-1:0]         limit,
  output logic [NUM_CMP*CNT_W-1:0] cmp,
  output logic [CTRL_W-1:0]        flag_en,
  output logic [EVCFG_W-1:0]       ev_cfg,
  output logic [FLAG_W-1:0]        flags,
  output logic                     irq
);
  logic [CTRL_W-1:0]  clk_cfg_q, run_cfg_q, flag_en_q;
  logic [CNT_W-1:0]   limit_q;
  logic [EVCFG_W-1:0] ev_cfg_q;
  logic [FLAG_W-1:0]  flags_q;
  logic               irq_q;

  // Configuration words with width masking (R3); reset values (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cfg_q <= '0;
      run_cfg_q <= RUN_CFG_RST;
      limit_q   <= '0;
      flag_en_q <= '0;
      ev_cfg_q  <= '0;
    end else if (wr_en) begin
      case (grp)
        G_CLKCFG: clk_cfg_q <= wdata[CTRL_W-1:0];
        G_RUNCFG: run_cfg_q <= wdata[CTRL_W-1:0];
        G_LIMIT:  limit_q   <= wdata;
        G_FLAGEN: flag_en_q <= wdata[CTRL_W-1:0];
        G_EVCFG:  ev_cfg_q  <= wdata[EVCFG_W-1:0];
        default: ;
      endcase
    end
  end

  // One compare word per compare unit
  for (genvar m = 0; m < NUM_CMP; m++) begin : g_cmp
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q <= '0;
      end else if (wr_en && (int'(grp) == CMP_BASE + m)) begin
        cmp_q <= wdata;
      end
    end
    assign cmp[m*CNT_W +: CNT_W] = cmp_q;
  end

  // Sticky flags: cleared by a read, a set on the same edge wins (R7, R8)
  // Writes never reach this register (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= (flag_clr ? '0 : flags_q) | flag_set;
    end
  end

  // Registered interrupt line (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(flags_q & flag_en_q);
    end
  end

  assign clk_cfg = clk_cfg_q;
  assign run_cfg = run_cfg_q;
  assign limit   = limit_q;
  assign flag_en = flag_en_q;
  assign ev_cfg  = ev_cfg_q;
  assign flags   = flags_q;
  assign irq     = irq_q;
endmodule

// File: rtl/tmr_bank_rd_mux.sv
module tmr_bank_rd_mux
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                            hit,
  input  grp_e                            grp,
  input  logic [CH_W-1:0]                 ch,
  input  logic [NUM_CH*CTRL_W-1:0]        clk_cfg_all,
  input  logic [NUM_CH*CTRL_W-1:0]        run_cfg_all,
  input  logic [NUM_CH*CNT_W-1:0]         count_all,
  input  logic [NUM_CH*CNT_W-1:0]         limit_all,
  input  logic [NUM_CH*NUM_CMP*CNT_W-1:0] cmp_all,
  input  logic [NUM_CH*FLAG_W-1:0]        flags_all,
  input  logic [NUM_CH*CTRL_W-1:0]        flag_en_all,
  input  logic [NUM_CH*EVCFG_W-1:0]       ev_cfg_all,
  input  logic [NUM_CH*CNT_W-1:0]         evcount_all,
  output logic [DATA_W-1:0]               rdata
);
  int ci;
  int mi;

  // Zero-extended read selection (R2, R3, R6, R10)
  always_comb begin
    ci    = int'(ch);
    mi    = int'(grp) - CMP_BASE;
    rdata = '0;
    if (hit) begin
      case (grp)
        G_CLKCFG: rdata = DATA_W'(clk_cfg_all[ci*CTRL_W +: CTRL_W]);
        G_RUNCFG: rdata = DATA_W'(run_cfg_all[ci*CTRL_W +: CTRL_W]);
        G_COUNT:  rdata = DATA_W'(count_all[ci*CNT_W +: CNT_W]);
        G_LIMIT:  rdata = DATA_W'(limit_all[ci*CNT_W +: CNT_W]);
        G_CMP0, G_CMP1, G_CMP2:
                  rdata = DATA_W'(cmp_all[(ci*NUM_CMP + mi)*CNT_W +: CNT_W]);
        G_FLAGS:  rdata = DATA_W'(flags_all[ci*FLAG_W +: FLAG_W]);
        G_FLAGEN: rdata = DATA_W'(flag_en_all[ci*CTRL_W +: CTRL_W]);
        G_EVCFG:  rdata = DATA_W'(ev_cfg_all[ci*EVCFG_W +: EVCFG_W]);
        G_EVCNT:  rdata = DATA_W'(evcount_all[ci*CNT_W +: CNT_W]);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_CH  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_rdata,
  input  logic [NUM_CH*CNT_W-1:0]         ch_count_i,
  input  logic [NUM_CH*CNT_W-1:0]         ch_evcount_i,
  input  logic [NUM_CH*FLAG_W-1:0]        ch_flag_set_i,
  output logic [NUM_CH*CTRL_W-1:0]        ch_clk_cfg_o,
  output logic [NUM_CH*CTRL_W-1:0]        ch_run_cfg_o,
  output logic [NUM_CH*CNT_W-1:0]         ch_limit_o,
  output logic [NUM_CH*NUM_CMP*CNT_W-1:0] ch_cmp_o,
  output logic [NUM_CH*EVCFG_W-1:0]       ch_ev_cfg_o,
  output logic [NUM_CH-1:0]               irq_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              hit;
  grp_e              grp;
  logic [CH_W-1:0]   ch;
  logic              rd_take, wr_take;
  logic [DATA_W-1:0] rd_mux;
  logic [NUM_CH*FLAG_W-1:0] flags_all;
  logic [NUM_CH*CTRL_W-1:0] flag_en_all;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^req_wdata[DATA_W-1:CNT_W];

  // Never stalls (R5)
  assign req_ready = 1'b1;
  assign rd_take   = req_valid && !req_write;
  assign wr_take   = req_valid &&  req_write && hit;

  tmr_bank_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
    .addr (req_addr),
    .hit  (hit),
    .grp  (grp),
    .ch   (ch)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = (int'(ch) == c);

    tmr_bank_chan_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_take && sel),
      .grp      (grp),
      .wdata    (req_wdata[CNT_W-1:0]),
      .flag_clr (rd_take && hit && sel && (grp == G_FLAGS)),
      .flag_set (ch_flag_set_i[c*FLAG_W +: FLAG_W]),
      .clk_cfg  (ch_clk_cfg_o[c*CTRL_W +: CTRL_W]),
      .run_cfg  (ch_run_cfg_o[c*CTRL_W +: CTRL_W]),
      .limit    (ch_limit_o[c*CNT_W +: CNT_W]),
      .cmp      (ch_cmp_o[c*NUM_CMP*CNT_W +: NUM_CMP*CNT_W]),
      .flag_en  (flag_en_all[c*CTRL_W +: CTRL_W]),
      .ev_cfg   (ch_ev_cfg_o[c*EVCFG_W +: EVCFG_W]),
      .flags    (flags_all[c*FLAG_W +: FLAG_W]),
      .irq      (irq_o[c])
    );
  end

  tmr_bank_rd_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd_mux (
    .hit         (hit),
    .grp         (grp),
    .ch          (ch),
    .clk_cfg_all (ch_clk_cfg_o),
    .run_cfg_all (ch_run_cfg_o),
    .count_all   (ch_count_i),
    .limit_all   (ch_limit_o),
    .cmp_all     (ch_cmp_o),
    .flags_all   (flags_all),
    .flag_en_all (flag_en_all),
    .ev_cfg_all  (ch_ev_cfg_o),
    .evcount_all (ch_evcount_i),
    .rdata       (rd_mux)
  );

  // One-cycle registered read response (R5)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_take;
      if (rd_take) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 3,
  parameter int FLAG_W = 6,
  parameter int CTRL_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_write,
  input logic [ADDR_W-1:0]        req_addr,
  input logic                     rsp_valid,
  input logic [DATA_W-1:0]        rsp_rdata,
  input logic [NUM_CH*FLAG_W-1:0] ch_flag_set_i,
  input logic [NUM_CH*CTRL_W-1:0] ch_run_cfg_o
);
  localparam logic [ADDR_W-1:0] A_FLAGS0 = ADDR_W'(8'h54);

  p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_no_spurious_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_unaligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr[1:0] != 2'b00)) |=> (rsp_rdata == '0));

  p_count_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr >= ADDR_W'(8'h18)) && (req_addr <= ADDR_W'(8'h20)))
    |=> (rsp_rdata[DATA_W-1:16] == '0));

  p_run_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(ch_run_cfg_o));

  p_flags_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == A_FLAGS0 && ch_flag_set_i[FLAG_W-1:0] == '0)
    ##1 (req_valid && !req_write && req_addr == A_FLAGS0)
    |=> (rsp_rdata == '0));
endmodule

bind tmr_bank tmr_bank_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NUM_CH (NUM_CH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .ch_flag_set_i (ch_flag_set_i),
  .ch_run_cfg_o  (ch_run_cfg_o)
);

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         req_valid = 0, req_write = 0;
  logic         req_ready;
  logic [7:0]   req_addr = 0;
  logic [31:0]  req_wdata = 0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [47:0]  ch_count_i = 0, ch_evcount_i = 0;
  logic [17:0]  ch_flag_set_i = 0;
  logic [17:0]  ch_clk_cfg_o, ch_run_cfg_o;
  logic [47:0]  ch_limit_o;
  logic [143:0] ch_cmp_o;
  logic [8:0]   ch_ev_cfg_o;
  logic [2:0]   irq_o;

  int total = 0, bad = 0;

  // bench model
  logic [5:0]  m_clk [3], m_run [3], m_en [3], m_st [3];
  logic [15:0] m_lim [3];
  logic [15:0] m_cmp [3][3];
  logic [2:0]  m_ev [3];

  tmr_bank u_tmr_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ch_count_i(ch_count_i),
    .ch_evcount_i(ch_evcount_i), .ch_flag_set_i(ch_flag_set_i),
    .ch_clk_cfg_o(ch_clk_cfg_o), .ch_run_cfg_o(ch_run_cfg_o),
    .ch_limit_o(ch_limit_o), .ch_cmp_o(ch_cmp_o), .ch_ev_cfg_o(ch_ev_cfg_o),
    .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int w, g, c;
    w = int'(a >> 2); g = w / 3; c = w % 3;
    if (a[1:0] != 0 || g >= 11) return 0;
    case (g)
      0: return 32'(m_clk[c]);
      1: return 32'(m_run[c]);
      2: return 32'(ch_count_i[c*16 +: 16]);
      3: return 32'(m_lim[c]);
      4, 5, 6: return 32'(m_cmp[c][g-4]);
      7: return 32'(m_st[c]);
      8: return 32'(m_en[c]);
      9: return 32'(m_ev[c]);
      default: return 32'(ch_evcount_i[c*16 +: 16]);
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
    int w, g, c;
    w = int'(a >> 2); g = w / 3; c = w % 3;
    if (a[1:0] != 0 || g >= 11) return;
    case (g)
      0: m_clk[c] = d[5:0];
      1: m_run[c] = d[5:0];
      3: m_lim[c] = d[15:0];
      4, 5, 6: m_cmp[c][g-4] = d[15:0];
      8: m_en[c] = d[5:0];
      9: m_ev[c] = d[2:0];
      default: ;
    endcase
  endtask

  task automatic check_irq(input string tag);
    for (int c = 0; c < 3; c++)
      chk(irq_o[c] == |(m_st[c] & m_en[c]), tag, 32'(irq_o[c]), 32'(|(m_st[c] & m_en[c])));
  endtask

  task automatic check_cfg();
    for (int c = 0; c < 3; c++) begin
      chk(ch_clk_cfg_o[c*6 +: 6] == m_clk[c], "R12 clk cfg", 32'(ch_clk_cfg_o[c*6 +: 6]), 32'(m_clk[c]));
      chk(ch_run_cfg_o[c*6 +: 6] == m_run[c], "R12 run cfg", 32'(ch_run_cfg_o[c*6 +: 6]), 32'(m_run[c]));
      chk(ch_limit_o[c*16 +: 16] == m_lim[c], "R12 limit", 32'(ch_limit_o[c*16 +: 16]), 32'(m_lim[c]));
      chk(ch_ev_cfg_o[c*3 +: 3] == m_ev[c], "R12 ev cfg", 32'(ch_ev_cfg_o[c*3 +: 3]), 32'(m_ev[c]));
      for (int m = 0; m < 3; m++)
        chk(ch_cmp_o[(c*3+m)*16 +: 16] == m_cmp[c][m], "R12 cmp",
            32'(ch_cmp_o[(c*3+m)*16 +: 16]), 32'(m_cmp[c][m]));
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    model_wr(a, d);
    chk(rsp_valid == 0, "R5 no rsp on write", 32'(rsp_valid), 0);
  endtask

  // read and compare; flags bits in ev (for channel evc) arrive on the request edge
  task automatic do_rd_ev(input logic [7:0] a, input int evc, input logic [5:0] ev, input string tag);
    logic [31:0] e;
    int w, g, c;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    if (evc >= 0) ch_flag_set_i[evc*6 +: 6] = ev;
    e = exp_rd(a);
    @(negedge clk);
    req_valid = 0; ch_flag_set_i = 0;
    chk(rsp_valid == 1, "R5 rsp valid", 32'(rsp_valid), 1);
    chk(rsp_rdata == e, tag, rsp_rdata, e);
    w = int'(a >> 2); g = w / 3; c = w % 3;
    if (a[1:0] == 0 && g == 7) m_st[c] = 0;
    if (evc >= 0) m_st[evc] = m_st[evc] | ev;
    @(negedge clk);
    chk(rsp_valid == 0, "R5 single pulse", 32'(rsp_valid), 0);
  endtask

  task automatic do_rd(input logic [7:0] a, input string tag);
    do_rd_ev(a, -1, 6'h0, tag);
  endtask

  task automatic flag_pulse(input int c, input logic [5:0] v);
    @(negedge clk);
    ch_flag_set_i[c*6 +: 6] = v;
    @(negedge clk);
    ch_flag_set_i = 0;
    m_st[c] = m_st[c] | v;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] a;
    void'($urandom(32'd4242));
    for (int c = 0; c < 3; c++) begin
      m_clk[c] = 0; m_run[c] = 6'h21; m_en[c] = 0; m_st[c] = 0; m_lim[c] = 0; m_ev[c] = 0;
      for (int m = 0; m < 3; m++) m_cmp[c][m] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4: reset state
    chk(ch_run_cfg_o == {3{6'h21}}, "R4 run cfg reset", 32'(ch_run_cfg_o), 32'({3{6'h21}}));
    chk(irq_o == 0, "R4 irq reset", 32'(irq_o), 0);
    chk(req_ready == 1, "R5 ready", 32'(req_ready), 1);
    for (int c = 0; c < 3; c++) do_rd(8'(12 + 4*c), "R4 run cfg readback");
    check_cfg();

    // R1/R2: interleaving of reload limit (0x24, 0x28, 0x2C)
    do_wr(8'h24, 32'h1111); do_wr(8'h28, 32'h2222); do_wr(8'h2C, 32'h3333);
    do_rd(8'h24, "R1 limit ch0"); do_rd(8'h28, "R1 limit ch1"); do_rd(8'h2C, "R2 limit ch2");
    chk(ch_limit_o == 48'h3333_2222_1111, "R2 limit outputs", 32'(ch_limit_o[31:0]), 32'h2222_1111);

    // R3: masking
    do_wr(8'h00, 32'hFFFF_FFFF); do_rd(8'h00, "R3 clk cfg mask");
    do_wr(8'h70, 32'hFFFF_FFFF); do_rd(8'h70, "R3 ev cfg mask");
    do_wr(8'h40, 32'hABCD_9876); do_rd(8'h40, "R3 cmp mask");
    do_wr(8'h68, 32'hFFFF_FFC0); do_rd(8'h68, "R3 enable mask");

    // R6: read-only count, zero extension
    ch_count_i = 48'hFEDC_8001_7FFF;
    ch_evcount_i = 48'h0102_FFFF_0304;
    do_wr(8'h1C, 32'h5555); do_rd(8'h1C, "R6 count ch1");
    do_wr(8'h7C, 32'h5555); do_rd(8'h7C, "R6 evcount ch1");
    do_rd(8'h20, "R6 count ch2");

    // R7/R9/R11: flags, ignored write, irq timing
    do_wr(8'h60, 32'h04);
    @(negedge clk);
    ch_flag_set_i[5:0] = 6'h04;
    @(negedge clk);
    ch_flag_set_i = 0; m_st[0] = 6'h04;
    chk(irq_o[0] == 0, "R11 irq not yet", 32'(irq_o[0]), 0);
    @(negedge clk);
    chk(irq_o[0] == 1, "R11 irq one cycle later", 32'(irq_o[0]), 1);
    do_wr(8'h54, 32'h0); do_wr(8'h54, 32'h3F);
    check_irq("R9 irq after flag write");
    flag_pulse(0, 6'h10);
    do_rd(8'h54, "R7 R9 flags kept");
    do_rd(8'h54, "R8 flags cleared");
    check_irq("R11 irq after clear");

    // R8: set on same edge as clear survives
    flag_pulse(2, 6'h03);
    do_rd_ev(8'h5C, 2, 6'h20, "R8 read returns old flags");
    do_rd(8'h5C, "R8 same-edge set survives");

    // R10: unmapped
    do_wr(8'h84, 32'hFFFF); do_wr(8'h25, 32'hFFFF); do_wr(8'hFC, 32'hFFFF);
    do_rd(8'h84, "R10 out of range"); do_rd(8'h25, "R10 unaligned"); do_rd(8'h26, "R10 unaligned");
    do_rd(8'h24, "R10 limit untouched");
    check_cfg();

    // seeded random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 10);
      a = 8'($urandom % 136);
      if ($urandom % 5 != 0) a[1:0] = 2'b00;
      if ($urandom % 20 == 0) a = 8'($urandom);
      d = $urandom;
      ch_count_i = {16'($urandom), 16'($urandom), 16'($urandom)};
      ch_evcount_i = {16'($urandom), 16'($urandom), 16'($urandom)};
      if (op < 4) do_wr(a, d);
      else if (op < 8) do_rd(a, "R1 R2 R3 random read");
      else flag_pulse(int'($urandom % 3), 6'($urandom));
      @(negedge clk);
      check_irq("R11 random irq");
    end
    check_cfg();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule